// File: doc/BRIEF.md
# EEPROM Burst Transfer Controller

This block sits between a host register bus and a byte-wide EEPROM request port. The host can move one byte at a time between the EEPROM and a data register, in either direction. It can also start a burst, in which consecutive EEPROM bytes are copied into on-chip memory through a byte write port. Only one operation runs at a time. Every EEPROM request is bounded by a wait limit. When that limit expires, the operation is abandoned and a sticky error flag is raised.

A burst starts at EEPROM address 0 if nothing has been accessed since reset. Otherwise it starts at the address just after the last location touched, whether that access was a single byte or the tail of an earlier burst. The memory target address is built from two parts. A 9-bit base field that the host programs forms the upper bits. The lower 15 bits of the EEPROM address form the lower bits, so the top EEPROM address bit never reaches memory.

The host register map uses word offsets on `reg_addr`:

| Offset | Register | Contents |
|--------|----------|----------|
| 0 | ADDR | 16-bit EEPROM byte address |
| 1 | DATA | 8-bit data |
| 2 | CTRL | bit 1 = read, bit 0 = write |
| 3 | BURST | bit 0 = start / active |
| 4 | BASE | 9-bit memory base |
| 5 | LEN | 17-bit burst byte count |
| 6 | STATUS | bit 0 = busy (read-only), bit 1 = error (write 1 to clear) |

Reads are combinational.

Top module: `eeprom_burst_ctrl`

## Requirements
- R1: After reset every register (offsets 0 to 6) reads 0 and `ee_req` is low.
- R2: Writing CTRL with bit 1 set while idle reads the EEPROM byte at ADDR into DATA[7:0]. CTRL bit 1 reads 1 until the byte is in DATA, then reads 0.
- R3: Writing CTRL with bit 0 set (and bit 1 clear) while idle writes DATA[7:0] to the EEPROM at ADDR with `ee_we` high. CTRL bit 0 reads 0 once the EEPROM acknowledges.
- R4: A CTRL write with both bits set performs only the read; the EEPROM sees no write.
- R5: A burst started with no single or burst access since reset fetches from EEPROM address 0 upward.
- R6: Otherwise a burst starts at the address one above the most recently requested EEPROM address, wrapping from 0xFFFF to 0.
- R7: A burst copies LEN bytes, one memory write per acknowledged byte. A start with LEN = 0 issues no request and leaves the block idle.
- R8: A burst stops after the byte at EEPROM address 0xFFFF even if fewer than LEN bytes were copied.
- R9: Each memory write goes to {BASE[8:0], EEPROM address[14:0]} with the fetched byte; EEPROM address bit 15 is ignored.
- R10: While busy (STATUS bit 0 = 1), host writes to every register are ignored, so a second operation cannot start.
- R11: A request unacknowledged for TIMEOUT_CYC cycles is dropped, the operation bits clear, and STATUS bit 1 sets and stays set until the host writes 1 to it.
- R12: `ee_req` holds with a stable `ee_addr` until acknowledged or timed out, and falls for at least one cycle after each acknowledge.
- R13: BURST bit 0 reads 1 while a burst runs and returns to 0 by itself when it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ee_req | output | 1 | EEPROM byte request, held until acknowledge |
| ee_we | output | 1 | Request is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle acknowledge from the EEPROM |
| ee_rdata | input | 8 | Byte read, valid with `ee_ack` |
| mem_we | output | 1 | On-chip memory byte write strobe |
| mem_addr | output | 24 | On-chip memory byte address |
| mem_wdata | output | 8 | On-chip memory write data |

## Verification
On every cycle, the assertions check the following:
- the EEPROM handshake shape: a held request with a stable address, and a gap after each acknowledge;
- that at most one operation flag is ever set;
- that a timeout always leaves the block idle with the error flag set;
- that every memory write carries the low 15 bits of the EEPROM address it came from.

Some behaviour only the bench scenarios can show. This covers where a burst starts after reset, after single accesses and after earlier bursts. It also covers truncation at the top of the EEPROM space and wrap back to 0, and the empty burst. Finally, it covers the exact cycle count before a timeout and the fact that host writes during a busy period change nothing.

// File: rtl/eebc_pkg.sv
package eebc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SREQ = 2'd1,
        ST_BREQ = 2'd2,
        ST_BGAP = 2'd3
    } eebc_state_e;

    localparam logic [2:0] RA_ADDR  = 3'd0;
    localparam logic [2:0] RA_DATA  = 3'd1;
    localparam logic [2:0] RA_CTRL  = 3'd2;
    localparam logic [2:0] RA_BURST = 3'd3;
    localparam logic [2:0] RA_BASE  = 3'd4;
    localparam logic [2:0] RA_LEN   = 3'd5;
    localparam logic [2:0] RA_STAT  = 3'd6;

    localparam int CTRL_RD_BIT = 1;
    localparam int CTRL_WR_BIT = 0;
    localparam int STAT_ERR_BIT = 1;
endpackage

// File: rtl/eebc_wait_timer.sv
module eebc_wait_timer #(
    parameter int LIMIT = 64,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ack,
    output logic expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active)
            cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = active && !ack && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/eebc_mem_addr.sv
module eebc_mem_addr #(
    parameter int BASE_W = 9,
    parameter int LO_W   = 15,
    localparam int EE_AW = LO_W + 1
) (
    input  logic [BASE_W-1:0]      base,
    input  logic [EE_AW-1:0]       ee_addr,
    output logic [BASE_W+LO_W-1:0] mem_addr
);
    logic unused_top;
    assign unused_top = ee_addr[EE_AW-1];
    assign mem_addr   = {base, ee_addr[LO_W-1:0]};
endmodule

// File: rtl/eeprom_burst_ctrl.sv
module eeprom_burst_ctrl
    import eebc_pkg::*;
#(
    parameter int MEM_AW      = 24,
    parameter int BASE_W      = 9,
    parameter int TIMEOUT_CYC = 64,
    localparam int LO_W  = MEM_AW - BASE_W,
    localparam int EE_AW = LO_W + 1,
    localparam int LEN_W = EE_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    input  logic              ee_ack,
    input  logic [7:0]        ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    typedef struct packed {
        eebc_state_e       st;
        logic [EE_AW-1:0]  addr;
        logic [7:0]        data;
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic              rd;
        logic              wr;
        logic              err;
        logic              touched;
        logic [EE_AW-1:0]  cont;
        logic [EE_AW-1:0]  cur;
        logic [LEN_W-1:0]  cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tmo_expire;
    logic busy;
    logic burst_on;
    logic err_flag;
    logic [2:0] op_flags;
    logic [EE_AW-1:0] cur_inc;
    logic [LEN_W-1:0] cnt_inc;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[31:LEN_W];
    assign busy     = (ctl_q.st != ST_IDLE);
    assign burst_on = (ctl_q.st == ST_BREQ) || (ctl_q.st == ST_BGAP);
    assign err_flag = ctl_q.err;
    assign op_flags = {ctl_q.rd, ctl_q.wr, burst_on};
    assign cur_inc  = ctl_q.cur + 1'b1;
    assign cnt_inc  = ctl_q.cnt + 1'b1;

    eebc_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (ee_req),
        .ack    (ee_ack),
        .expire (tmo_expire)
    );

    eebc_mem_addr #(.BASE_W(BASE_W), .LO_W(LO_W)) u_maddr (
        .base     (ctl_q.base),
        .ee_addr  (ctl_q.cur),
        .mem_addr (mem_addr)
    );

    always_comb begin
        ctl_d = ctl_q;
        // host register writes, accepted only while idle
        if (!busy && reg_we) begin
            case (reg_addr)
                RA_ADDR: ctl_d.addr = reg_wdata[EE_AW-1:0];
                RA_DATA: ctl_d.data = reg_wdata[7:0];
                RA_CTRL: begin
                    if (reg_wdata[CTRL_RD_BIT] || reg_wdata[CTRL_WR_BIT]) begin
                        ctl_d.rd      = reg_wdata[CTRL_RD_BIT];
                        ctl_d.wr      = !reg_wdata[CTRL_RD_BIT];
                        ctl_d.st      = ST_SREQ;
                        ctl_d.touched = 1'b1;
                        ctl_d.cont    = ctl_q.addr + 1'b1;
                    end
                end
                RA_BURST: begin
                    if (reg_wdata[0] && (ctl_q.len != '0)) begin
                        ctl_d.st      = ST_BREQ;
                        ctl_d.cur     = ctl_q.touched ? ctl_q.cont : '0;
                        ctl_d.cnt     = '0;
                        ctl_d.touched = 1'b1;
                    end
                end
                RA_BASE: ctl_d.base = reg_wdata[BASE_W-1:0];
                RA_LEN:  ctl_d.len  = reg_wdata[LEN_W-1:0];
                RA_STAT: if (reg_wdata[STAT_ERR_BIT]) ctl_d.err = 1'b0;
                default: ;
            endcase
        end
        // operation sequencing
        case (ctl_q.st)
            ST_SREQ: begin
                if (ee_ack) begin
                    if (ctl_q.rd) ctl_d.data = ee_rdata;
                    ctl_d.rd = 1'b0;
                    ctl_d.wr = 1'b0;
                    ctl_d.st = ST_IDLE;
                end else if (tmo_expire) begin
                    ctl_d.rd  = 1'b0;
                    ctl_d.wr  = 1'b0;
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end
            end
            ST_BREQ: begin
                if (ee_ack) begin
                    ctl_d.cnt  = cnt_inc;
                    ctl_d.cont = cur_inc;
                    if ((cnt_inc == ctl_q.len) || (&ctl_q.cur)) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.st  = ST_BGAP;
                        ctl_d.cur = cur_inc;
                    end
                end else if (tmo_expire) begin
                    ctl_d.cont = cur_inc;
                    ctl_d.err  = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            ST_BGAP: ctl_d.st = ST_BREQ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_ADDR:  reg_rdata[EE_AW-1:0]  = ctl_q.addr;
            RA_DATA:  reg_rdata[7:0]        = ctl_q.data;
            RA_CTRL:  reg_rdata[1:0]        = {ctl_q.rd, ctl_q.wr};
            RA_BURST: reg_rdata[0]          = burst_on;
            RA_BASE:  reg_rdata[BASE_W-1:0] = ctl_q.base;
            RA_LEN:   reg_rdata[LEN_W-1:0]  = ctl_q.len;
            RA_STAT:  reg_rdata[1:0]        = {err_flag, busy};
            default:  reg_rdata = '0;
        endcase
    end

    assign ee_req    = (ctl_q.st == ST_SREQ) || (ctl_q.st == ST_BREQ);
    assign ee_we     = (ctl_q.st == ST_SREQ) && ctl_q.wr;
    assign ee_addr   = burst_on ? ctl_q.cur : ctl_q.addr;
    assign ee_wdata  = ctl_q.data;
    assign mem_we    = (ctl_q.st == ST_BREQ) && ee_ack;
    assign mem_wdata = ee_rdata;
endmodule

module eebc_checker #(
    parameter int EE_AW  = 16,
    parameter int LO_W   = 15,
    parameter int MEM_AW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ee_req,
    input logic              ee_we,
    input logic              ee_ack,
    input logic [EE_AW-1:0]  ee_addr,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              tmo,
    input logic              err_flag,
    input logic [2:0]        op_flags
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && !ee_ack && !tmo |=> ee_req && $stable(ee_addr));
    // R12
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && ee_ack |=> !ee_req);
    // R11
    tmo_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !ee_req && err_flag && (op_flags == 3'b000));
    // R10
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_flags));
    // R9
    mem_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ee_req && (mem_addr[LO_W-1:0] == ee_addr[LO_W-1:0]));
    // R3
    wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_we |-> ee_req && (op_flags == 3'b010));
endmodule

bind eeprom_burst_ctrl eebc_checker #(.EE_AW(EE_AW), .LO_W(LO_W), .MEM_AW(MEM_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ee_req   (ee_req),
    .ee_we    (ee_we),
    .ee_ack   (ee_ack),
    .ee_addr  (ee_addr),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .tmo      (tmo_expire),
    .err_flag (err_flag),
    .op_flags (op_flags)
);

// File: tb/eeprom_burst_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_burst_ctrl_bench;
    localparam int TMO = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    eeprom_burst_ctrl #(.TIMEOUT_CYC(TMO)) u_eeprom_burst_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack),
        .ee_rdata(ee_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // EEPROM model
    logic [7:0] ee_mem [int];
    int  ack_lat = 1;
    bit  hang = 0;
    int  wcnt = 0;

    function automatic logic [7:0] ee_byte(input logic [15:0] a);
        if (ee_mem.exists(int'(a))) return ee_mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(negedge clk) begin
        if (ee_ack) begin
            ee_ack = 1'b0;
            wcnt = 0;
        end else if (ee_req && !hang) begin
            if (wcnt >= ack_lat) begin
                ee_ack = 1'b1;
                ee_rdata = ee_byte(ee_addr);
                if (ee_we) ee_mem[int'(ee_addr)] = ee_wdata;
                wcnt = 0;
            end else begin
                wcnt = wcnt + 1;
            end
        end else begin
            wcnt = 0;
        end
    end

    // monitors
    logic [23:0] mlog_a [$];
    logic [7:0]  mlog_d [$];
    int req_cycles = 0;
    int acc_cnt = 0;
    int wr_cnt = 0;
    always @(posedge clk) begin
        if (mem_we) begin
            mlog_a.push_back(mem_addr);
            mlog_d.push_back(mem_wdata);
        end
        if (ee_req) req_cycles++;
        if (ee_req && ee_ack) acc_cnt++;
        if (ee_req && ee_ack && ee_we) wr_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(3'd6, v);
            if (!v[0]) return;
        end
        chk(1'b0, "wait_idle busy stuck", 1, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic single(input logic [15:0] a, input logic [1:0] op);
        reg_wr(3'd0, 32'(a));
        reg_wr(3'd2, 32'(op));
        wait_idle();
    endtask

    task automatic run_burst(input logic [16:0] len);
        reg_wr(3'd5, 32'(len));
        mlog_a.delete();
        mlog_d.delete();
        reg_wr(3'd3, 32'd1);
        wait_idle();
    endtask

    task automatic check_burst(input string tag, input logic [15:0] start, input int n, input logic [8:0] base);
        chk(mlog_a.size() == n, {tag, " byte count"}, mlog_a.size(), n);
        for (int k = 0; k < n && k < mlog_a.size(); k++) begin
            logic [15:0] ea;
            ea = start + 16'(k);
            chk(mlog_a[k] == {base, ea[14:0]}, {tag, " mem addr"}, mlog_a[k], {base, ea[14:0]});
            chk(mlog_d[k] == ee_byte(ea), {tag, " mem data"}, mlog_d[k], ee_byte(ea));
        end
    endtask

    initial begin
        logic [31:0] v;
        int a0, w0;
        do_reset();

        // R1 reset state
        for (int r = 0; r < 7; r++) begin
            reg_rd(3'(r), v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(ee_req == 1'b0, "R1 ee_req after reset", ee_req, 0);

        // R5 first burst from 0, R13 active bit, latency sweep
        reg_wr(3'd4, 32'h0A3);
        reg_wr(3'd5, 32'd5);
        mlog_a.delete(); mlog_d.delete();
        reg_wr(3'd3, 32'd1);
        reg_rd(3'd3, v);
        chk(v[0] == 1'b1, "R13 burst bit while active", v, 1);
        wait_idle();
        reg_rd(3'd3, v);
        chk(v == 0, "R13 burst bit self clears", v, 0);
        check_burst("R5 R7 burst from zero", 16'h0000, 5, 9'h0A3);

        // R6 continuation after burst, latency sweep
        for (int lat = 0; lat < 4; lat++) begin
            ack_lat = lat;
            run_burst(17'd3);
            check_burst("R6 burst after burst", 16'(5 + 3 * lat), 3, 9'h0A3);
        end
        ack_lat = 1;

        // R3 / R2 write then read back, address sweep
        for (int i = 0; i < 12; i++) begin
            logic [15:0] a;
            logic [7:0] d;
            a = 16'(i * 16'h1555 + 16'h0011);
            d = 8'(i * 37 + 3);
            reg_wr(3'd1, 32'(d));
            reg_wr(3'd0, 32'(a));
            reg_wr(3'd2, 32'h1);
            wait_idle();
            reg_rd(3'd2, v);
            chk(v == 0, "R3 write bit self clears", v, 0);
            chk(ee_mem.exists(int'(a)) && ee_mem[int'(a)] == d, "R3 byte written", ee_byte(a), d);
            reg_wr(3'd1, 32'h0);
            ack_lat = 3;
            reg_wr(3'd2, 32'h2);
            reg_rd(3'd2, v);
            chk(v == 32'h2, "R2 read bit set while busy", v, 2);
            wait_idle();
            ack_lat = 1;
            reg_rd(3'd2, v);
            chk(v == 0, "R2 read bit self clears", v, 0);
            reg_rd(3'd1, v);
            chk(v == 32'(d), "R2 read data", v, d);
        end

        // R6 + R9 continuation after single read, bit 15 dropped
        single(16'h7FFE, 2'b10);
        reg_wr(3'd4, 32'h155);
        run_burst(17'd2);
        check_burst("R6 R9 burst after single", 16'h7FFF, 2, 9'h155);

        // R8 end of space, then wrap
        single(16'hFFFC, 2'b10);
        run_burst(17'd10);
        check_burst("R8 stop at top", 16'hFFFD, 3, 9'h155);
        run_burst(17'd1);
        check_burst("R6 wrap to zero", 16'h0000, 1, 9'h155);

        // R7 zero length
        a0 = acc_cnt;
        run_burst(17'd0);
        chk(mlog_a.size() == 0, "R7 zero length no writes", mlog_a.size(), 0);
        chk(acc_cnt == a0, "R7 zero length no request", acc_cnt - a0, 0);
        reg_rd(3'd3, v);
        chk(v == 0, "R7 zero length idle", v, 0);
        run_burst(17'd2);
        check_burst("R7 continuation unchanged", 16'h0001, 2, 9'h155);

        // R9 base sweep
        for (int b = 0; b < 4; b++) begin
            logic [8:0] bv;
            bv = (b == 0) ? 9'h000 : (b == 1) ? 9'h001 : (b == 2) ? 9'h0AA : 9'h1FF;
            reg_wr(3'd4, 32'(bv));
            run_burst(17'd1);
            check_burst("R9 base sweep", 16'(3 + b), 1, bv);
        end

        // R4 both bits: read only
        w0 = wr_cnt;
        reg_wr(3'd1, 32'h3C);
        single(16'h0400, 2'b11);
        chk(wr_cnt == w0, "R4 no eeprom write", wr_cnt - w0, 0);
        reg_rd(3'd1, v);
        chk(v == 32'(ee_byte(16'h0400)), "R4 read performed", v, ee_byte(16'h0400));

        // R10 writes ignored while busy
        ack_lat = 10;
        a0 = acc_cnt; w0 = wr_cnt;
        reg_wr(3'd0, 32'h0123);
        reg_wr(3'd2, 32'h2);
        reg_rd(3'd6, v);
        chk(v[0] == 1'b1, "R10 busy status", v, 1);
        reg_wr(3'd0, 32'h0456);
        reg_wr(3'd1, 32'h77);
        reg_wr(3'd2, 32'h1);
        reg_wr(3'd3, 32'h1);
        wait_idle();
        ack_lat = 1;
        reg_rd(3'd0, v);
        chk(v == 32'h0123, "R10 address write ignored", v, 32'h0123);
        chk(acc_cnt - a0 == 1, "R10 single access only", acc_cnt - a0, 1);
        chk(wr_cnt == w0, "R10 no write started", wr_cnt - w0, 0);
        reg_rd(3'd1, v);
        chk(v == 32'(ee_byte(16'h0123)), "R10 data from first op", v, ee_byte(16'h0123));

        // R11 timeout on single read
        hang = 1;
        a0 = req_cycles;
        reg_wr(3'd2, 32'h2);
        wait_idle();
        chk(req_cycles - a0 == TMO, "R11 request held cycles", req_cycles - a0, TMO);
        reg_rd(3'd6, v);
        chk(v == 32'h2, "R11 error set", v, 2);
        reg_rd(3'd2, v);
        chk(v == 0, "R11 request bit cleared", v, 0);
        reg_rd(3'd6, v);
        chk(v == 32'h2, "R11 error sticky", v, 2);
        reg_wr(3'd6, 32'h2);
        reg_rd(3'd6, v);
        chk(v == 0, "R11 error cleared", v, 0);

        // R11 timeout in burst
        run_burst(17'd4);
        chk(mlog_a.size() == 0, "R11 burst timeout no writes", mlog_a.size(), 0);
        reg_rd(3'd6, v);
        chk(v == 32'h2, "R11 burst timeout error", v, 2);
        reg_rd(3'd3, v);
        chk(v == 0, "R11 burst bit cleared", v, 0);
        hang = 0;

        // R5 again after a fresh reset
        do_reset();
        reg_wr(3'd4, 32'h042);
        run_burst(17'd2);
        check_burst("R5 burst from zero after reset", 16'h0000, 2, 9'h042);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule